// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A one-cycle oscillator tick input, pulsing at roughly 33 kHz, drives a prescaler. The prescaler wraps at a programmable terminal count and marks each wrap as a one-second event. A 4-bit fractional trim can lengthen chosen seconds by one oscillator tick. This corrects a crystal whose rate does not divide evenly into whole ticks per second.

Software reaches the block through a flat 32-bit register port with a byte address, a write strobe, write data and combinational read data. A new time is staged in a load register and only reaches the running counter at the next one-second event. Writing the load register, or writing the calibration word, restarts the prescaler, so that event comes exactly one full second after the write. A 32-bit alarm compare and a two-source interrupt unit raise a per-second interrupt and an alarm interrupt. The interrupt unit has write-one-to-clear status and separate unmask and mask strobes. Two control bits, for oscillator enable and battery switching, are storage only.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset the calibration readback (0x0C) reads 0x198233, the mask (0x24) reads 0x3, status (0x20), current time (0x10) and control (0x40) read 0, and both interrupt outputs are low.
- R2: With fraction correction off, a seconds event occurs on every (term+1)-th oscillator tick, where term is calibration bits 15:0. Current tick (0x14) reads the live prescaler count and returns to 0 at the event. Each event adds 1 to current time and sets status bit 0.
- R3: Any write to calibration (0x08) clears the prescaler count, so the next event comes term+1 ticks later. The readback at 0x0C returns the written bits 20:0.
- R4: A write to set-time (0x00) is readable at once at 0x04 and restarts the prescaler. Current time keeps its old value until the next event, takes the written value at that event, and counts up from it afterwards.
- R5: In status, bit 0 is the seconds event and bit 1 is the alarm. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: Writing 1 to a bit of 0x28 unmasks that source. Writing 1 to a bit of 0x2C masks it. The mask register (0x24) reads 1 for a masked source, and a mask write wins over an unmask write in the same cycle.
- R7: irq_sec equals status bit 0 AND NOT mask bit 0; irq_alarm equals status bit 1 AND NOT mask bit 1.
- R8: The alarm register (0x18) is read/write. Status bit 1 sets at the seconds event on which current time takes the alarm value, and at no other event.
- R9: In control (0x40), bits 31 and 24 are stored and read back, other bits read 0, and the stored bits do not affect time keeping.
- R10: With calibration bit 20 set and fraction f in bits 19:16, the 16 seconds that follow a calibration write take 16·(term+1)+f ticks in total. Exactly f of those seconds are one tick longer. With bit 20 clear, f has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench sweeps all sixteen fraction values with a terminal count of 3. For each value it checks that the sixteenth second lands on tick 64+f and not one tick earlier. A trim applied one second late, or a carry applied on the wrong side of the accumulator, shifts that boundary and fails at once. A staged time is checked to stay invisible for a whole second and then to appear exactly. A design that loaded it immediately, or forgot the prescaler restart, shows the wrong value at 0x10 or a nonzero tick count. The alarm is checked to fire on the matching second only and not on the one after. Write-zero to status, and masking a pending source, are checked to change the pins only as the mask dictates.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEC_W  = 32;
  localparam int TICK_W = 16;
  localparam int FRAC_W = 4;
  localparam int CAL_W  = TICK_W + FRAC_W + 1;
  localparam int IRQ_N  = 2;

  localparam int IRQ_SEC = 0;
  localparam int IRQ_ALM = 1;

  localparam int CTL_OSC_BIT = 24;
  localparam int CTL_BAT_BIT = 31;

  localparam logic [CAL_W-1:0] CAL_RST = 21'h198233;

  localparam logic [7:0] A_LOAD_WR = 8'h00;
  localparam logic [7:0] A_LOAD_RD = 8'h04;
  localparam logic [7:0] A_CAL_WR  = 8'h08;
  localparam logic [7:0] A_CAL_RD  = 8'h0C;
  localparam logic [7:0] A_NOW     = 8'h10;
  localparam logic [7:0] A_TICK    = 8'h14;
  localparam logic [7:0] A_ALARM   = 8'h18;
  localparam logic [7:0] A_STS     = 8'h20;
  localparam logic [7:0] A_MASK    = 8'h24;
  localparam logic [7:0] A_UNMASK  = 8'h28;
  localparam logic [7:0] A_SETMASK = 8'h2C;
  localparam logic [7:0] A_CTL     = 8'h40;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  localparam int CNT_W = TICK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              restart,
  input  logic [TICK_W-1:0] term,
  input  logic [FRAC_W-1:0] frac,
  input  logic              fr_en,
  output logic [CNT_W-1:0]  tick_cnt,
  output logic              sec_evt
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, limit;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   acc_sum;
  logic              at_lim, stretch, cnt_en;

  // The carry of this second's accumulation stretches this same second.
  always_comb begin
    acc_sum = {1'b0, acc_q} + {1'b0, frac};
    stretch = fr_en & acc_sum[FRAC_W];
    limit   = {1'b0, term} + CNT_W'(stretch);
    at_lim  = (cnt_q == limit);
    sec_evt = osc_tick & at_lim & ~restart;
    cnt_en  = restart | osc_tick;
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    if (restart) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (osc_tick) begin
      if (at_lim) begin
        cnt_d = '0;
        if (fr_en) acc_d = acc_sum[FRAC_W-1:0];
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign tick_cnt = cnt_q;
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_evt,
  input  logic             load_wr,
  input  logic             alarm_wr,
  input  logic [SEC_W-1:0] wdata,
  output logic [SEC_W-1:0] now_sec,
  output logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] alarm_val,
  output logic             alarm_hit
);
  logic [SEC_W-1:0] now_q, now_d, load_q, alarm_q;
  logic             pend_q, pend_d, pend_en;

  always_comb begin
    now_d     = pend_q ? load_q : now_q + SEC_W'(1);
    alarm_hit = sec_evt & (now_d == alarm_q);
    pend_en   = load_wr | sec_evt;
    pend_d    = load_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else if (sec_evt) now_q <= now_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= '0;
    else if (load_wr) load_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else if (alarm_wr) alarm_q <= wdata;
  end

  assign now_sec   = now_q;
  assign load_val  = load_q;
  assign alarm_val = alarm_q;
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raise,
  input  logic [N-1:0] clr_w1,
  input  logic [N-1:0] unmask_w1,
  input  logic [N-1:0] mask_w1,
  output logic [N-1:0] sts,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic sts_q, sts_d, sts_en, msk_q, msk_d, msk_en;

    always_comb begin
      sts_en = raise[i] | clr_w1[i];
      sts_d  = raise[i];
      msk_en = unmask_w1[i] | mask_w1[i];
      msk_d  = mask_w1[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= 1'b0;
      else if (sts_en) sts_q <= sts_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) msk_q <= 1'b1;
      else if (msk_en) msk_q <= msk_d;
    end

    assign sts[i]  = sts_q;
    assign mask[i] = msk_q;
    assign irq[i]  = sts_q & ~msk_q;
  end
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int ADDR_W = rtc_pkg::ADDR_W,
  parameter int DATA_W = rtc_pkg::DATA_W,
  parameter int SEC_W  = rtc_pkg::SEC_W,
  parameter int TICK_W = rtc_pkg::TICK_W,
  parameter int FRAC_W = rtc_pkg::FRAC_W,
  localparam int CAL_W = TICK_W + FRAC_W + 1,
  localparam int CNT_W = TICK_W + 1,
  localparam int IRQ_N = rtc_pkg::IRQ_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  import rtc_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             wr_load, wr_cal, wr_alarm, wr_sts, wr_unmask, wr_setmask, wr_ctl;
  logic             restart, sec_evt, alarm_hit;
  logic [CAL_W-1:0] cal_q;
  logic             osc_en_q, bat_en_q;
  logic [CNT_W-1:0] tick_cnt;
  logic [SEC_W-1:0] now_sec, load_val, alarm_val;
  logic [IRQ_N-1:0] sts, mask, irq, raise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_comb begin
    wr_load    = reg_wr && (reg_addr == ADDR_W'(A_LOAD_WR));
    wr_cal     = reg_wr && (reg_addr == ADDR_W'(A_CAL_WR));
    wr_alarm   = reg_wr && (reg_addr == ADDR_W'(A_ALARM));
    wr_sts     = reg_wr && (reg_addr == ADDR_W'(A_STS));
    wr_unmask  = reg_wr && (reg_addr == ADDR_W'(A_UNMASK));
    wr_setmask = reg_wr && (reg_addr == ADDR_W'(A_SETMASK));
    wr_ctl     = reg_wr && (reg_addr == ADDR_W'(A_CTL));
    restart    = wr_load | wr_cal;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cal_q <= CAL_RST;
    else if (wr_cal) cal_q <= reg_wdata[CAL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_en_q <= 1'b0;
      bat_en_q <= 1'b0;
    end else if (wr_ctl) begin
      osc_en_q <= reg_wdata[CTL_OSC_BIT];
      bat_en_q <= reg_wdata[CTL_BAT_BIT];
    end
  end

  rtc_prescaler #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_ni),
    .osc_tick (osc_tick),
    .restart  (restart),
    .term     (cal_q[TICK_W-1:0]),
    .frac     (cal_q[TICK_W+FRAC_W-1:TICK_W]),
    .fr_en    (cal_q[CAL_W-1]),
    .tick_cnt (tick_cnt),
    .sec_evt  (sec_evt)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_secs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .sec_evt   (sec_evt),
    .load_wr   (wr_load),
    .alarm_wr  (wr_alarm),
    .wdata     (reg_wdata[SEC_W-1:0]),
    .now_sec   (now_sec),
    .load_val  (load_val),
    .alarm_val (alarm_val),
    .alarm_hit (alarm_hit)
  );

  always_comb begin
    raise          = '0;
    raise[IRQ_SEC] = sec_evt;
    raise[IRQ_ALM] = alarm_hit;
  end

  rtc_irq #(.N(IRQ_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .raise     (raise),
    .clr_w1    (wr_sts     ? reg_wdata[IRQ_N-1:0] : '0),
    .unmask_w1 (wr_unmask  ? reg_wdata[IRQ_N-1:0] : '0),
    .mask_w1   (wr_setmask ? reg_wdata[IRQ_N-1:0] : '0),
    .sts       (sts),
    .mask      (mask),
    .irq       (irq)
  );

  assign irq_sec   = irq[IRQ_SEC];
  assign irq_alarm = irq[IRQ_ALM];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(A_LOAD_RD): reg_rdata = DATA_W'(load_val);
      ADDR_W'(A_CAL_RD):  reg_rdata = DATA_W'(cal_q);
      ADDR_W'(A_NOW):     reg_rdata = DATA_W'(now_sec);
      ADDR_W'(A_TICK):    reg_rdata = DATA_W'(tick_cnt);
      ADDR_W'(A_ALARM):   reg_rdata = DATA_W'(alarm_val);
      ADDR_W'(A_STS):     reg_rdata = DATA_W'(sts);
      ADDR_W'(A_MASK):    reg_rdata = DATA_W'(mask);
      ADDR_W'(A_CTL): begin
        reg_rdata[CTL_OSC_BIT] = osc_en_q;
        reg_rdata[CTL_BAT_BIT] = bat_en_q;
      end
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk #(
  parameter int SEC_W = 32,
  parameter int TICK_W = 16,
  parameter int CNT_W = 17
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              sec_evt,
  input logic              wr_cal,
  input logic              wr_setmask,
  input logic              wr_alarm,
  input logic [31:0]       reg_wdata,
  input logic [TICK_W-1:0] term,
  input logic [CNT_W-1:0]  tick_cnt,
  input logic [SEC_W-1:0]  now_sec,
  input logic [SEC_W-1:0]  alarm_val,
  input logic [1:0]        sts,
  input logic [1:0]        mask,
  input logic              irq_sec,
  input logic              irq_alarm
);
  // R2
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_cnt <= ({1'b0, term} + CNT_W'(1)));

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sec_evt |=> (tick_cnt == '0));

  // R2
  sec_sts_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sec_evt |=> sts[0]);

  // R3
  cal_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_cal |=> (tick_cnt == '0));

  // R4
  time_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !sec_evt |=> $stable(now_sec));

  // R6
  mask_win_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_setmask && reg_wdata[0]) |=> mask[0]);

  // R7
  irq_sec_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_sec |-> (sts[0] && !mask[0]));

  // R7
  irq_alarm_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_alarm |-> (sts[1] && !mask[1]));

  // R8
  alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(sts[1]) && !$past(wr_alarm)) |-> (now_sec == alarm_val));
endmodule

bind rtc_sec_core rtc_sec_core_chk #(.SEC_W(SEC_W), .TICK_W(TICK_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .sec_evt    (sec_evt),
  .wr_cal     (wr_cal),
  .wr_setmask (wr_setmask),
  .wr_alarm   (wr_alarm),
  .reg_wdata  (reg_wdata),
  .term       (cal_q[TICK_W-1:0]),
  .tick_cnt   (tick_cnt),
  .now_sec    (now_sec),
  .alarm_val  (alarm_val),
  .sts        (sts),
  .mask       (mask),
  .irq_sec    (irq_sec),
  .irq_alarm  (irq_alarm)
);

// File: tb/rtc_sec_core_bench.sv
module rtc_sec_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_tick = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_sec, irq_alarm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_sec_core u_rtc_sec_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_sec   (irq_sec),
    .irq_alarm (irq_alarm)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  task automatic rd_chk(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk("R1", "cal readback", 8'h0C, 32'h0019_8233);
    rd_chk("R1", "mask", 8'h24, 32'h3);
    rd_chk("R1", "status", 8'h20, 32'h0);
    rd_chk("R1", "time", 8'h10, 32'h0);
    rd_chk("R1", "control", 8'h40, 32'h0);
    check("R1", "irq pins", {30'b0, irq_alarm, irq_sec}, 32'h0);

    // R2 period term+1 = 4 with fraction off
    wr(8'h08, 32'h0000_0003);
    rd_chk("R3", "cal readback", 8'h0C, 32'h3);
    rd_chk("R3", "tick after cal", 8'h14, 32'h0);
    ticks(3);
    rd_chk("R2", "tick count", 8'h14, 32'h3);
    rd_chk("R2", "time before wrap", 8'h10, 32'h0);
    ticks(1);
    rd_chk("R2", "time after wrap", 8'h10, 32'h1);
    rd_chk("R2", "tick wrapped", 8'h14, 32'h0);
    rd_chk("R2", "sec status", 8'h20, 32'h1);

    // R3 calibration write restarts prescaler
    ticks(2);
    rd_chk("R3", "tick mid", 8'h14, 32'h2);
    wr(8'h08, 32'h0000_0003);
    rd_chk("R3", "tick cleared", 8'h14, 32'h0);
    ticks(3);
    rd_chk("R3", "no early second", 8'h10, 32'h1);
    ticks(1);
    rd_chk("R3", "full second", 8'h10, 32'h2);

    // R4 staged time load
    ticks(1);
    wr(8'h00, 32'd1000);
    rd_chk("R4", "staged readback", 8'h04, 32'd1000);
    rd_chk("R4", "time unchanged", 8'h10, 32'd2);
    rd_chk("R4", "prescaler restarted", 8'h14, 32'h0);
    ticks(3);
    rd_chk("R4", "still old", 8'h10, 32'd2);
    ticks(1);
    rd_chk("R4", "loaded", 8'h10, 32'd1000);
    ticks(4);
    rd_chk("R4", "counts on", 8'h10, 32'd1001);

    // R5 write-one-to-clear
    wr(8'h20, 32'h0);
    rd_chk("R5", "write zero keeps", 8'h20, 32'h1);
    wr(8'h20, 32'h1);
    rd_chk("R5", "write one clears", 8'h20, 32'h0);

    // R6 / R7 mask and pins
    wr(8'h28, 32'h1);
    rd_chk("R6", "unmask sec", 8'h24, 32'h2);
    check("R7", "irq_sec idle", {31'b0, irq_sec}, 32'h0);
    ticks(4);
    check("R7", "irq_sec raised", {31'b0, irq_sec}, 32'h1);
    wr(8'h2C, 32'h1);
    rd_chk("R6", "mask sec", 8'h24, 32'h3);
    check("R7", "irq_sec masked", {31'b0, irq_sec}, 32'h0);
    rd_chk("R6", "status kept", 8'h20, 32'h1);
    wr(8'h20, 32'h3);

    // R8 alarm, time now 1002
    wr(8'h18, 32'd1004);
    rd_chk("R8", "alarm readback", 8'h18, 32'd1004);
    wr(8'h28, 32'h2);
    ticks(4);
    rd_chk("R8", "time 1003", 8'h10, 32'd1003);
    check("R8", "no alarm yet", {31'b0, irq_alarm}, 32'h0);
    ticks(4);
    rd_chk("R8", "time 1004", 8'h10, 32'd1004);
    check("R8", "alarm pin", {31'b0, irq_alarm}, 32'h1);
    rd_chk("R8", "alarm status", 8'h20, 32'h3);
    wr(8'h20, 32'h2);
    check("R5", "alarm cleared", {31'b0, irq_alarm}, 32'h0);
    ticks(4);
    rd_chk("R8", "no refire", 8'h20, 32'h1);

    // R9 control storage
    wr(8'h40, 32'hFFFF_FFFF);
    rd_chk("R9", "control bits", 8'h40, 32'h8100_0000);
    ticks(4);
    rd_chk("R9", "time unaffected", 8'h10, 32'd1006);

    // R10 fraction sweep with term 3
    for (int f = 0; f < 16; f++) begin
      wr(8'h08, (32'h1 << 20) | (32'(f) << 16) | 32'h3);
      rd(8'h10, base);
      ticks(63 + f);
      rd_chk("R10", $sformatf("f=%0d fifteen seconds", f), 8'h10, base + 32'd15);
      ticks(1);
      rd_chk("R10", $sformatf("f=%0d sixteen seconds", f), 8'h10, base + 32'd16);
      rd_chk("R10", $sformatf("f=%0d tick zero", f), 8'h14, 32'h0);
    end
    wr(8'h08, (32'd7 << 16) | 32'h3);
    rd(8'h10, base);
    ticks(64);
    rd_chk("R10", "fraction off ignored", 8'h10, base + 32'd16);

    done = 1'b1;
    finish_run();
  end
endmodule